// File: doc/BRIEF.md
# Pending Preload Request Tracker

This block keeps a short associative record of data-cache block addresses that the look-ahead preload logic has requested and that have not yet returned. A new preload is recorded only if its block is not already tracked. Recorded preloads go out to the next memory level one at a time, in the order they arrived. The tracker also sees every demand miss from the data cache. A demand read miss that finds its block already tracked waits for that fetch and is flagged as hit-wait. A demand read miss that finds nothing is sent to memory ahead of every buffered preload. A write miss on a tracked block marks that entry so its returning data is thrown away.

Each of the `ENTRIES` slots is `ENT_FREE`, `ENT_QUEUED` (recorded, not yet accepted by memory) or `ENT_FLIGHT` (accepted by memory, data pending). The transitions are alloc (free to queued), issue (queued to flight), drop (queued to free, on flush) and release (flight to free, on fill). The issue controller has three states. From `CTL_IDLE` it offers a request and moves to `CTL_PRELOAD` or `CTL_DEMAND` when memory accepts it. It returns to `CTL_IDLE` on the fill response. Only one fetch is ever in progress, and it is never withdrawn. A flush clears all queued preloads and leaves the in-flight one alone. If a demand read is hit-waiting on a queued entry that the flush clears, that wait becomes a demand request of its own.

Top module: `pend_fetch_list`

## Requirements
- R1: The tracker holds `ENTRIES` (4 by default) preloads. `list_full` is 1 exactly when every slot is occupied (queued or in flight), and `pre_accept` is 0 while it is 1.
- R2: `pre_accept` is combinational in the cycle `pre_valid` is presented. It is 0 if the address equals an occupied entry, a pending or in-flight demand, or a demand read presented in the same cycle. Otherwise the address is recorded at that clock edge.
- R3: A demand read (`dmd_valid`=1, `dmd_write`=0) whose address matches an occupied entry sends no new request. `hit_wait` is 1 from the next cycle until the cycle after that block's fill, and then falls to 0.
- R4: A demand read that matches nothing is offered in the next cycle with `mem_req_demand`=1, ahead of queued preloads. The offer and its address stay unchanged until `mem_req_ready`.
- R5: After memory accepts a request (`mem_req_valid` and `mem_req_ready` both 1), `mem_req_valid` stays 0 until `fill_valid` returns. A demand miss arriving meanwhile waits.
- R6: A write miss (`dmd_write`=1) that matches an entry marks it discard, and its fill gives `fill_keep`=0. A write miss that matches nothing issues no request.
- R7: `flush` frees every queued entry. None of them is ever offered, their addresses can be recorded again, and a preload presented together with `flush` is refused.
- R8: A preload fill with `fill_err`=1 gives `fill_keep`=0 and frees the entry.
- R9: Queued preloads are offered in arrival order.
- R10: An entry is freed by its fill. `list_full` falls and the same address is accepted from the next cycle.
- R11: The in-flight preload survives a flush, and its fill gives `fill_keep`=1 if not discarded.
- R12: If a flush clears a queued entry that a demand read is hit-waiting on, that block is offered as a demand request, and `hit_wait` stays 1 until its fill.
- R13: After reset, `list_full`, `mem_req_valid`, `hit_wait` and `fill_keep` are 0.
- R14: Demand fills always give `fill_keep`=1. Preload fills give 1 unless discarded or errored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pre_valid | input | 1 | Preload request present |
| pre_addr | input | ADDR_W | Preload block address |
| pre_accept | output | 1 | Preload recorded this cycle |
| flush | input | 1 | Drop all queued preloads |
| dmd_valid | input | 1 | Demand miss pulse |
| dmd_write | input | 1 | 1 = write miss, 0 = read miss |
| dmd_addr | input | ADDR_W | Demand miss block address |
| hit_wait | output | 1 | Demand read waits on a tracked block |
| list_full | output | 1 | All slots occupied, look-ahead must stall |
| mem_req_valid | output | 1 | Request offered to memory |
| mem_req_ready | input | 1 | Memory accepts the offer |
| mem_req_addr | output | ADDR_W | Offered block address |
| mem_req_demand | output | 1 | 1 = demand fetch, 0 = preload |
| fill_valid | input | 1 | Fill response for the fetch in progress |
| fill_err | input | 1 | Fill raised an exception |
| fill_keep | output | 1 | Returned data should be written to the cache |

## Verification
Four rotations of four addresses check arrival order, the full boundary, refusal of duplicates and refill after release. A FIFO pointer slip or an off-by-one in the full flag would reorder or lose addresses. Priority is tested by a demand miss that arrives behind queued preloads and one that arrives during an in-flight preload. A design that aborts or pre-empts would raise a second offer before the fill. Hit-wait is tested against both in-flight and queued blocks. Discard, exception and flush cases check `fill_keep` and the absence of further offers. The flush that clears a hit-waited queued block is the sharpest case: a design that simply drops the entry would leave `hit_wait` stuck high with nothing outstanding.

// File: rtl/pfl_pkg.sv
package pfl_pkg;
    typedef enum logic [1:0] {
        ENT_FREE   = 2'd0,
        ENT_QUEUED = 2'd1,
        ENT_FLIGHT = 2'd2
    } ent_state_e;

    typedef enum logic [1:0] {
        CTL_IDLE    = 2'd0,
        CTL_PRELOAD = 2'd1,
        CTL_DEMAND  = 2'd2
    } ctl_state_e;
endpackage

// File: rtl/pfl_entry.sv
module pfl_entry
    import pfl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic              issue_i,
    input  logic              release_i,
    input  logic              drop_i,
    input  logic              discard_i,
    input  logic [ADDR_W-1:0] alloc_addr_i,
    input  logic [ADDR_W-1:0] probe_pre_i,
    input  logic [ADDR_W-1:0] probe_dmd_i,
    output ent_state_e        state_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              discard_o,
    output logic              hit_pre_o,
    output logic              hit_dmd_o
);
    ent_state_e        st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    logic              disc_q;
    logic              occupied;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ENT_FREE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ENT_FREE:   if (alloc_i) st_d = ENT_QUEUED;
            ENT_QUEUED: begin
                if (issue_i)     st_d = ENT_FLIGHT;
                else if (drop_i) st_d = ENT_FREE;
            end
            ENT_FLIGHT: if (release_i) st_d = ENT_FREE;
            default:    st_d = ENT_FREE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            disc_q <= 1'b0;
        end else if (alloc_i) begin
            addr_q <= alloc_addr_i;
            disc_q <= 1'b0;
        end else if (discard_i && occupied) begin
            disc_q <= 1'b1;
        end
    end

    assign occupied  = (st_q != ENT_FREE);
    assign state_o   = st_q;
    assign addr_o    = addr_q;
    assign discard_o = disc_q;
    assign hit_pre_o = occupied && (addr_q == probe_pre_i);
    assign hit_dmd_o = occupied && (addr_q == probe_dmd_i);

    AST_ALLOC_ONLY_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> st_q == ENT_FREE); // R1
    AST_ISSUE_ONLY_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
        issue_i |-> st_q == ENT_QUEUED); // R9
    AST_FLIGHT_SURVIVES_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ENT_FLIGHT && drop_i && !release_i) |=> st_q == ENT_FLIGHT); // R11
    AST_RELEASE_ONLY_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        release_i |-> st_q == ENT_FLIGHT); // R10
endmodule

// File: rtl/pfl_idx_fifo.sv
module pfl_idx_fifo #(
    parameter int DEPTH = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [IDX_W-1:0] push_idx_i,
    input  logic             pop_i,
    input  logic             clear_i,
    output logic [IDX_W-1:0] head_o,
    output logic             empty_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [IDX_W-1:0] slot_q [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else if (clear_i) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_i) wr_q <= bump(wr_q);
            if (pop_i)  rd_q <= bump(rd_q);
            if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
            else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_i && !clear_i) slot_q[wr_q] <= push_idx_i;
    end

    assign head_o  = slot_q[rd_q];
    assign empty_o = (cnt_q == '0);

    AST_FIFO_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !clear_i) |-> cnt_q < CNT_W'(DEPTH)); // R1
    AST_FIFO_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> cnt_q != '0); // R9
endmodule

// File: rtl/pfl_issue_ctl.sv
module pfl_issue_ctl
    import pfl_pkg::*;
#(
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dmd_pend_i,
    input  logic             queue_empty_i,
    input  logic [IDX_W-1:0] head_idx_i,
    input  logic             mem_ready_i,
    input  logic             fill_valid_i,
    output ctl_state_e       state_o,
    output logic             offer_o,
    output logic             offer_dmd_o,
    output logic             launch_o,
    output logic [IDX_W-1:0] flight_idx_o
);
    ctl_state_e       state_q, state_d;
    logic [IDX_W-1:0] flight_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= CTL_IDLE;
            flight_q <= '0;
        end else begin
            state_q <= state_d;
            if (launch_o && !dmd_pend_i) flight_q <= head_idx_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CTL_IDLE: begin
                if (launch_o) state_d = dmd_pend_i ? CTL_DEMAND : CTL_PRELOAD;
            end
            CTL_PRELOAD: if (fill_valid_i) state_d = CTL_IDLE;
            CTL_DEMAND:  if (fill_valid_i) state_d = CTL_IDLE;
            default:     state_d = CTL_IDLE;
        endcase
    end

    always_comb begin
        offer_o     = (state_q == CTL_IDLE) && (dmd_pend_i || !queue_empty_i);
        offer_dmd_o = offer_o && dmd_pend_i;
        launch_o    = offer_o && mem_ready_i;
    end

    assign state_o      = state_q;
    assign flight_idx_o = flight_q;

    AST_LAUNCH_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        launch_o |=> state_q != CTL_IDLE); // R5
    AST_FILL_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid_i |-> state_q != CTL_IDLE); // R5
endmodule

// File: rtl/pend_fetch_list.sv
module pend_fetch_list
    import pfl_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pre_valid,
    input  logic [ADDR_W-1:0] pre_addr,
    output logic              pre_accept,
    input  logic              flush,
    input  logic              dmd_valid,
    input  logic              dmd_write,
    input  logic [ADDR_W-1:0] dmd_addr,
    output logic              hit_wait,
    output logic              list_full,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic              mem_req_demand,
    input  logic              fill_valid,
    input  logic              fill_err,
    output logic              fill_keep
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    ent_state_e        ent_st   [ENTRIES];
    logic [ADDR_W-1:0] ent_addr [ENTRIES];
    logic [ENTRIES-1:0] ent_disc, hit_pre, hit_dmd, occ_v;
    logic [ENTRIES-1:0] alloc_v, issue_v, release_v, disc_v;

    logic              have_free, dmd_hit;
    logic [IDX_W-1:0]  free_idx, hit_idx, head_idx, flight_idx;
    logic              q_empty;
    ctl_state_e        ctl_st;
    logic              offer, offer_dmd, launch, launch_pre, fill_pre, hw_clr;
    logic              dmd_rd, dmd_wr, pre_dup, dmd_busy;

    logic              dmd_pend_q;
    logic [ADDR_W-1:0] dmd_addr_q;
    logic              hw_q, hw_dmd_q;
    logic [IDX_W-1:0]  hw_idx_q;

    assign dmd_rd = dmd_valid && !dmd_write;
    assign dmd_wr = dmd_valid &&  dmd_write;

    // first free slot and first demand match
    always_comb begin
        have_free = 1'b0;
        free_idx  = '0;
        dmd_hit   = 1'b0;
        hit_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!occ_v[i]) begin
                have_free = 1'b1;
                free_idx  = IDX_W'(i);
            end
            if (hit_dmd[i]) begin
                dmd_hit = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign dmd_busy   = (dmd_pend_q || ctl_st == CTL_DEMAND) && (dmd_addr_q == pre_addr);
    assign pre_dup    = (|hit_pre) || dmd_busy || (dmd_rd && dmd_addr == pre_addr);
    assign pre_accept = pre_valid && !flush && have_free && !pre_dup;
    assign list_full  = !have_free;

    assign launch_pre = launch && !offer_dmd;
    assign fill_pre   = fill_valid && (ctl_st == CTL_PRELOAD);

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
            assign alloc_v[g]   = pre_accept && (free_idx == IDX_W'(g));
            assign issue_v[g]   = launch_pre && (head_idx == IDX_W'(g));
            assign release_v[g] = fill_pre && (flight_idx == IDX_W'(g));
            assign disc_v[g]    = dmd_wr && hit_dmd[g];
            assign occ_v[g]     = (ent_st[g] != ENT_FREE);

            pfl_entry #(.ADDR_W(ADDR_W)) u_entry (
                .clk          (clk),
                .rst_n        (rst_n),
                .alloc_i      (alloc_v[g]),
                .issue_i      (issue_v[g]),
                .release_i    (release_v[g]),
                .drop_i       (flush),
                .discard_i    (disc_v[g]),
                .alloc_addr_i (pre_addr),
                .probe_pre_i  (pre_addr),
                .probe_dmd_i  (dmd_addr),
                .state_o      (ent_st[g]),
                .addr_o       (ent_addr[g]),
                .discard_o    (ent_disc[g]),
                .hit_pre_o    (hit_pre[g]),
                .hit_dmd_o    (hit_dmd[g])
            );
        end
    endgenerate

    pfl_idx_fifo #(.DEPTH(ENTRIES), .IDX_W(IDX_W)) u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (pre_accept),
        .push_idx_i (free_idx),
        .pop_i      (launch_pre),
        .clear_i    (flush),
        .head_o     (head_idx),
        .empty_o    (q_empty)
    );

    pfl_issue_ctl #(.IDX_W(IDX_W)) u_ctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .dmd_pend_i    (dmd_pend_q),
        .queue_empty_i (q_empty),
        .head_idx_i    (head_idx),
        .mem_ready_i   (mem_req_ready),
        .fill_valid_i  (fill_valid),
        .state_o       (ctl_st),
        .offer_o       (offer),
        .offer_dmd_o   (offer_dmd),
        .launch_o      (launch),
        .flight_idx_o  (flight_idx)
    );

    assign hw_clr = fill_valid &&
                    ((ctl_st == CTL_PRELOAD && !hw_dmd_q && flight_idx == hw_idx_q) ||
                     (ctl_st == CTL_DEMAND && hw_dmd_q));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dmd_pend_q <= 1'b0;
            dmd_addr_q <= '0;
            hw_q       <= 1'b0;
            hw_dmd_q   <= 1'b0;
            hw_idx_q   <= '0;
        end else begin
            if (launch && offer_dmd) dmd_pend_q <= 1'b0;

            if (hw_q && !hw_dmd_q && flush &&
                ent_st[hw_idx_q] == ENT_QUEUED && !issue_v[hw_idx_q]) begin
                // waited-on block is being flushed: fetch it as a demand
                dmd_pend_q <= 1'b1;
                dmd_addr_q <= ent_addr[hw_idx_q];
                hw_dmd_q   <= 1'b1;
            end else if (hw_clr) begin
                hw_q <= 1'b0;
            end

            if (dmd_rd && !hw_q && !dmd_pend_q && ctl_st != CTL_DEMAND) begin
                if (!dmd_hit) begin
                    dmd_pend_q <= 1'b1;
                    dmd_addr_q <= dmd_addr;
                end else if (flush && ent_st[hit_idx] == ENT_QUEUED && !issue_v[hit_idx]) begin
                    dmd_pend_q <= 1'b1;
                    dmd_addr_q <= dmd_addr;
                    hw_q       <= 1'b1;
                    hw_dmd_q   <= 1'b1;
                end else if (!release_v[hit_idx]) begin
                    hw_q     <= 1'b1;
                    hw_idx_q <= hit_idx;
                    hw_dmd_q <= 1'b0;
                end
            end
        end
    end

    assign hit_wait       = hw_q;
    assign mem_req_valid  = offer;
    assign mem_req_demand = offer_dmd;
    assign mem_req_addr   = dmd_pend_q ? dmd_addr_q : ent_addr[head_idx];
    assign fill_keep      = fill_valid &&
                            ((ctl_st == CTL_DEMAND) ||
                             (ctl_st == CTL_PRELOAD && !fill_err && !ent_disc[flight_idx]));

    AST_DEMAND_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_demand && !mem_req_ready)
        |=> (mem_req_valid && mem_req_demand && $stable(mem_req_addr))); // R4
    AST_NO_SECOND_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid); // R5
    AST_LAST_SLOT_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_accept && $countones(occ_v) == ENTRIES - 1 && !fill_pre) |=> list_full); // R1
    AST_CONVERTED_WAIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_wait && hw_dmd_q && fill_valid && ctl_st == CTL_DEMAND) |=> !hit_wait); // R12
endmodule

// File: tb/pend_fetch_list_tb.sv
module pend_fetch_list_tb_top;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pre_valid = 1'b0;
    logic [AW-1:0] pre_addr = '0;
    logic          pre_accept;
    logic          flush = 1'b0;
    logic          dmd_valid = 1'b0;
    logic          dmd_write = 1'b0;
    logic [AW-1:0] dmd_addr = '0;
    logic          hit_wait, list_full;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic          mem_req_demand;
    logic          fill_valid = 1'b0;
    logic          fill_err = 1'b0;
    logic          fill_keep;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    pend_fetch_list #(.ADDR_W(AW), .ENTRIES(4)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .pre_valid(pre_valid), .pre_addr(pre_addr), .pre_accept(pre_accept),
        .flush(flush),
        .dmd_valid(dmd_valid), .dmd_write(dmd_write), .dmd_addr(dmd_addr),
        .hit_wait(hit_wait), .list_full(list_full),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_demand(mem_req_demand),
        .fill_valid(fill_valid), .fill_err(fill_err), .fill_keep(fill_keep)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push_pre(input logic [AW-1:0] a, input logic exp, input string tag);
        pre_valid = 1'b1;
        pre_addr  = a;
        #1 chk(tag, pre_accept, exp);
        @(negedge clk);
        pre_valid = 1'b0;
    endtask

    task automatic take(input logic [AW-1:0] a, input logic dmd, input string tag);
        chk({tag, " valid"}, mem_req_valid, 1);
        chk({tag, " addr"}, mem_req_addr, a);
        chk({tag, " kind"}, mem_req_demand, dmd);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        chk("R5 no offer while in flight", mem_req_valid, 0);
    endtask

    task automatic fill(input logic err, input logic keep, input string tag);
        fill_valid = 1'b1;
        fill_err   = err;
        #1 chk(tag, fill_keep, keep);
        @(negedge clk);
        fill_valid = 1'b0;
        fill_err   = 1'b0;
    endtask

    task automatic miss(input logic [AW-1:0] a, input logic wr);
        dmd_valid = 1'b1;
        dmd_write = wr;
        dmd_addr  = a;
        @(negedge clk);
        dmd_valid = 1'b0;
        dmd_write = 1'b0;
    endtask

    task automatic do_flush();
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        logic [AW-1:0] seq [4];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R13 full after reset", list_full, 0);
        chk("R13 valid after reset", mem_req_valid, 0);
        chk("R13 hit_wait after reset", hit_wait, 0);
        chk("R13 keep after reset", fill_keep, 0);
        @(negedge clk);

        // R9 / R1 / R2 / R10: arrival-order sweep over four rotations
        for (int rot = 0; rot < 4; rot++) begin
            for (int k = 0; k < 4; k++) seq[k] = AW'(12'h100 + 16 * ((k + rot) % 4) + rot);
            push_pre(seq[0], 1, "R2 first accept");
            push_pre(seq[1], 1, "R2 second accept");
            push_pre(seq[0], 0, "R2 duplicate refused");
            push_pre(seq[2], 1, "R2 third accept");
            chk("R1 not full at three", list_full, 0);
            push_pre(seq[3], 1, "R2 fourth accept");
            chk("R1 full at four", list_full, 1);
            push_pre(AW'(12'h7F0 + rot), 0, "R1 refused when full");
            for (int k = 0; k < 4; k++) begin
                take(seq[k], 0, "R9 arrival order");
                fill(0, 1, "R14 preload keep");
                if (k == 0) chk("R10 full drops after fill", list_full, 0);
            end
            chk("R9 nothing left", mem_req_valid, 0);
            push_pre(seq[0], 1, "R10 address reusable");
            take(seq[0], 0, "R10 reissue");
            fill(0, 1, "R14 preload keep");
        end

        // R4 demand priority, R2 same-cycle demand dedup
        push_pre(12'h200, 1, "R2 accept");
        push_pre(12'h210, 1, "R2 accept");
        dmd_valid = 1'b1; dmd_write = 1'b0; dmd_addr = 12'h300;
        pre_valid = 1'b1; pre_addr = 12'h300;
        #1 chk("R2 refused against same-cycle demand", pre_accept, 0);
        @(negedge clk);
        dmd_valid = 1'b0; pre_valid = 1'b0;
        take(12'h300, 1, "R4 demand first");
        fill(0, 1, "R14 demand keep");
        take(12'h200, 0, "R9 after demand");
        fill(0, 1, "R14 preload keep");
        take(12'h210, 0, "R9 after demand");
        fill(0, 1, "R14 preload keep");

        // R5 no abort: demand arrives behind an in-flight preload
        push_pre(12'h220, 1, "R2 accept");
        take(12'h220, 0, "R5 preload issued");
        miss(12'h330, 0);
        chk("R5 demand waits", mem_req_valid, 0);
        @(negedge clk);
        chk("R5 demand still waits", mem_req_valid, 0);
        fill(0, 1, "R11 in-flight kept");
        take(12'h330, 1, "R4 demand after fill");
        fill(0, 1, "R14 demand keep");

        // R3 hit-wait on in-flight block
        push_pre(12'h240, 1, "R2 accept");
        take(12'h240, 0, "R3 preload issued");
        miss(12'h240, 0);
        chk("R3 hit_wait raised", hit_wait, 1);
        chk("R3 no new request", mem_req_valid, 0);
        repeat (3) @(negedge clk);
        chk("R3 hit_wait held", hit_wait, 1);
        fill(0, 1, "R3 block keep");
        chk("R3 hit_wait cleared", hit_wait, 0);
        chk("R3 no demand issued", mem_req_valid, 0);

        // R3 hit-wait on queued block
        push_pre(12'h250, 1, "R2 accept");
        miss(12'h250, 0);
        chk("R3 hit_wait on queued", hit_wait, 1);
        take(12'h250, 0, "R3 preload not demand");
        chk("R3 hit_wait in flight", hit_wait, 1);
        fill(0, 1, "R3 queued keep");
        chk("R3 queued wait cleared", hit_wait, 0);

        // R6 discard on in-flight and queued, unmatched write
        push_pre(12'h260, 1, "R2 accept");
        take(12'h260, 0, "R6 issued");
        miss(12'h260, 1);
        chk("R6 write match no request", mem_req_valid, 0);
        fill(0, 0, "R6 discarded in flight");
        push_pre(12'h270, 1, "R2 accept");
        miss(12'h270, 1);
        take(12'h270, 0, "R6 discarded still issued");
        fill(0, 0, "R6 discarded queued");
        miss(12'h280, 1);
        chk("R6 unmatched write no request", mem_req_valid, 0);
        chk("R6 unmatched write no wait", hit_wait, 0);

        // R8 exception drop
        push_pre(12'h290, 1, "R2 accept");
        take(12'h290, 0, "R8 issued");
        fill(1, 0, "R8 errored dropped");
        push_pre(12'h290, 1, "R8 entry freed");
        take(12'h290, 0, "R8 reissue");
        fill(0, 1, "R14 preload keep");

        // R7 / R11 flush
        push_pre(12'h2A0, 1, "R2 accept");
        push_pre(12'h2B0, 1, "R2 accept");
        push_pre(12'h2C0, 1, "R2 accept");
        take(12'h2A0, 0, "R11 issued before flush");
        pre_valid = 1'b1; pre_addr = 12'h2D0; flush = 1'b1;
        #1 chk("R7 preload with flush refused", pre_accept, 0);
        @(negedge clk);
        pre_valid = 1'b0; flush = 1'b0;
        chk("R7 not full after flush", list_full, 0);
        fill(0, 1, "R11 survivor kept");
        chk("R7 queued never offered", mem_req_valid, 0);
        @(negedge clk);
        chk("R7 queued never offered later", mem_req_valid, 0);
        push_pre(12'h2B0, 1, "R7 flushed address reusable");
        take(12'h2B0, 0, "R7 reissue");
        fill(0, 1, "R14 preload keep");

        // R12 flush of a hit-waited queued block
        push_pre(12'h400, 1, "R2 accept");
        push_pre(12'h410, 1, "R2 accept");
        take(12'h400, 0, "R12 first issued");
        miss(12'h410, 0);
        chk("R12 hit_wait on queued", hit_wait, 1);
        do_flush();
        chk("R12 hit_wait kept through flush", hit_wait, 1);
        chk("R12 busy no offer", mem_req_valid, 0);
        fill(0, 1, "R11 in-flight kept");
        chk("R12 hit_wait still held", hit_wait, 1);
        take(12'h410, 1, "R12 converted to demand");
        fill(0, 1, "R12 demand keep");
        chk("R12 hit_wait cleared", hit_wait, 0);
        chk("R12 idle after", mem_req_valid, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule